// File: doc/BRIEF.md
# NAND Boot Header Search Engine

At boot, before any software runs, this block looks through raw NAND storage for a page that begins with a valid boot identification block. It asks an external sector-fetch unit for the first sector of a candidate page. It then watches that sector stream past one byte at a time. When the header checks pass, it keeps two header fields. The first is the sector offset of the first-stage image. The second is the size of the boot code in bytes. It reports both together with the page where the header was found.

The scan covers a fixed, sparse set of pages. It starts at page 0 and moves forward in steps of 64 pages. A candidate is accepted only when two checks agree: a four-byte signature at the start of the data area, and a marker byte in the sector's metadata. If no candidate passes within the probe budget, the block raises a failure flag so that a fallback boot path can take over. The bytes it sees are already plaintext; decryption, ECC correction and the flash pin protocol are all handled elsewhere.

Each probe reads one 528-byte sector. The sector holds 512 data bytes, then 3 metadata bytes, then 13 check bytes. A page is always handled as if it held four such sectors, whatever its physical size, so only the first sector of a candidate page is read.

Top module: `nand_boot_scan`

## Requirements
- R1: After reset, found, fail and rdReq are 0, and stageOffset, codeSize and hitPage are all 0.
- R2: Probe number k (counting from 0) asserts rdReq with rdPage = 64*k. rdReq and rdPage stay unchanged until the cycle in which rdAck is seen high.
- R3: A candidate passes the signature check only if sector bytes 0, 1, 2 and 3 are 0x55, 0xAA, 0xF0 and 0x0F, in that order.
- R4: A candidate passes the marker check only if sector byte 514 equals 0x69. Byte 514 is the third metadata byte, which follows the 512 data bytes.
- R5: On a match, stageOffset is taken little-endian from sector bytes 12 (low) and 13 (high), and codeSize from bytes 508 (low) and 509 (high). Because the field is 16 bits wide, the size can never exceed 64 KiB.
- R6: On a match, found rises in the cycle after the 528th byte of that sector is taken, hitPage shows the matching page, and no further read is requested.
- R7: If all 50 probes fail, fail rises after the last byte of the probe at page 3136, and that is the final request. A match at that 50th probe gives found and not fail.
- R8: found and fail are never both high. Each stays high until the next start. A start given while done clears both flags and rescans from page 0. A start given during a scan has no effect.
- R9: Any number of idle cycles between bytes is tolerated. A byteValid that arrives while a request is still waiting for its acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a scan |
| rdReq | output | 1 | Request to read the first sector of rdPage |
| rdPage | output | PAGE_W | Page index of the pending request |
| rdAck | input | 1 | Fetch unit accepts the request |
| byteValid | input | 1 | byteData holds the next sector byte |
| byteData | input | 8 | Sector byte stream, in order from byte 0 |
| found | output | 1 | A valid header was located |
| fail | output | 1 | Probe budget used up without a match |
| stageOffset | output | 16 | First-stage offset in sectors |
| codeSize | output | 16 | Boot code size in bytes |
| hitPage | output | PAGE_W | Page that held the header |

## Verification
Two decisions can come from the same byte-accept edge: the header-accept decision, and the probe counter reaching its limit. The bench makes them coincide by placing the only valid header in the 50th probe, at page 3136. At that edge the block must give found with the captured fields and never fail. A second run leaves that probe invalid and expects fail after exactly 50 requests. Another overlap is a start that arrives while bytes are streaming. The bench judges it by the absence of any request back to page 0 and by an unchanged hit result.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  localparam int SECTOR_BYTES = 528;
  localparam int MARK_INDEX   = 514;
  localparam int OFF_INDEX    = 12;
  localparam int SIZE_INDEX   = 508;
  localparam logic [7:0] MARK_VALUE = 8'h69;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RECV, ST_DONE} scanState_t;

  typedef struct packed {
    logic clrSector;
    logic take;
    logic capture;
    logic clrOut;
  } ctrlStrobe_t;
endpackage

// File: rtl/nbs_datapath.sv
module nbs_datapath
  import nbs_pkg::*;
#(
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic [PAGE_W-1:0] curPage,
  output logic              sectorDone,
  output logic              hdrOk,
  output logic [15:0]       stageOffset,
  output logic [15:0]       codeSize,
  output logic [PAGE_W-1:0] hitPage
);
  localparam int IDX_W = $clog2(SECTOR_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);
  localparam logic [IDX_W-1:0] OFF_LO   = IDX_W'(OFF_INDEX);
  localparam logic [IDX_W-1:0] OFF_HI   = IDX_W'(OFF_INDEX + 1);
  localparam logic [IDX_W-1:0] SIZE_LO  = IDX_W'(SIZE_INDEX);
  localparam logic [IDX_W-1:0] SIZE_HI  = IDX_W'(SIZE_INDEX + 1);
  localparam logic [IDX_W-1:0] MARK_IDX = IDX_W'(MARK_INDEX);

  logic [IDX_W-1:0] byteIdx;
  logic             sigOk, markOk;
  logic [15:0]      offScratch, sizeScratch;
  logic             takeNow;
  logic [7:0]       sigExpect;

  assign takeNow    = strb.take & byteValid;
  assign sectorDone = takeNow && (byteIdx == LAST_IDX);
  assign hdrOk      = sigOk & markOk;

  always_comb begin
    case (byteIdx[1:0])
      2'd0:    sigExpect = 8'h55;
      2'd1:    sigExpect = 8'hAA;
      2'd2:    sigExpect = 8'hF0;
      default: sigExpect = 8'h0F;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx     <= '0;
      sigOk       <= 1'b0;
      markOk      <= 1'b0;
      offScratch  <= '0;
      sizeScratch <= '0;
    end else if (strb.clrSector) begin
      byteIdx <= '0;
      sigOk   <= 1'b1;
      markOk  <= 1'b0;
    end else if (takeNow) begin
      byteIdx <= (byteIdx == LAST_IDX) ? '0 : byteIdx + 1'b1;
      if (byteIdx < IDX_W'(4) && byteData != sigExpect) sigOk <= 1'b0;
      if (byteIdx == MARK_IDX) markOk <= (byteData == MARK_VALUE);
      if (byteIdx == OFF_LO)   offScratch[7:0]   <= byteData;
      if (byteIdx == OFF_HI)   offScratch[15:8]  <= byteData;
      if (byteIdx == SIZE_LO)  sizeScratch[7:0]  <= byteData;
      if (byteIdx == SIZE_HI)  sizeScratch[15:8] <= byteData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageOffset <= '0;
      codeSize    <= '0;
      hitPage     <= '0;
    end else if (strb.clrOut) begin
      stageOffset <= '0;
      codeSize    <= '0;
      hitPage     <= '0;
    end else if (strb.capture) begin
      stageOffset <= offScratch;
      codeSize    <= sizeScratch;
      hitPage     <= curPage;
    end
  end
endmodule

// File: rtl/nbs_ctrl.sv
module nbs_ctrl
  import nbs_pkg::*;
#(
  parameter int MAX_PROBES = 50,
  localparam int PROBE_W   = $clog2(MAX_PROBES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               rdAck,
  input  logic               sectorDone,
  input  logic               hdrOk,
  output logic               rdReq,
  output logic [PROBE_W-1:0] probeIdx,
  output ctrlStrobe_t        strb,
  output logic               found,
  output logic               fail
);
  localparam logic [PROBE_W-1:0] LAST_PROBE = PROBE_W'(MAX_PROBES - 1);

  scanState_t state;
  logic       idleLike;

  assign idleLike = (state == ST_IDLE) || (state == ST_DONE);
  assign rdReq    = (state == ST_REQ);

  always_comb begin
    strb           = '0;
    strb.clrSector = (state == ST_REQ);
    strb.take      = (state == ST_RECV);
    strb.capture   = (state == ST_RECV) && sectorDone && hdrOk;
    strb.clrOut    = idleLike && start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      probeIdx <= '0;
      found    <= 1'b0;
      fail     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start) begin
          state    <= ST_REQ;
          probeIdx <= '0;
          found    <= 1'b0;
          fail     <= 1'b0;
        end
        ST_REQ: if (rdAck) state <= ST_RECV;
        ST_RECV: if (sectorDone) begin
          if (hdrOk) begin
            found <= 1'b1;
            state <= ST_DONE;
          end else if (probeIdx == LAST_PROBE) begin
            fail  <= 1'b1;
            state <= ST_DONE;
          end else begin
            probeIdx <= probeIdx + 1'b1;
            state    <= ST_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_boot_scan.sv
module nand_boot_scan
  import nbs_pkg::*;
#(
  parameter int PAGE_W       = 16,
  parameter int PROBE_STRIDE = 64,
  parameter int MAX_PROBES   = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              rdReq,
  output logic [PAGE_W-1:0] rdPage,
  input  logic              rdAck,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  output logic              found,
  output logic              fail,
  output logic [15:0]       stageOffset,
  output logic [15:0]       codeSize,
  output logic [PAGE_W-1:0] hitPage
);
  localparam int PROBE_W = $clog2(MAX_PROBES);

  ctrlStrobe_t        strb;
  logic [PROBE_W-1:0] probeIdx;
  logic               sectorDone, hdrOk;

  assign rdPage = PAGE_W'(probeIdx) * PAGE_W'(PROBE_STRIDE);

  nbs_ctrl #(.MAX_PROBES(MAX_PROBES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rdAck(rdAck),
    .sectorDone(sectorDone), .hdrOk(hdrOk), .rdReq(rdReq),
    .probeIdx(probeIdx), .strb(strb), .found(found), .fail(fail)
  );

  nbs_datapath #(.PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteValid(byteValid),
    .byteData(byteData), .curPage(rdPage), .sectorDone(sectorDone),
    .hdrOk(hdrOk), .stageOffset(stageOffset), .codeSize(codeSize),
    .hitPage(hitPage)
  );
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int PAGE_W       = 16,
  parameter int PROBE_STRIDE = 64,
  parameter int MAX_PROBES   = 50
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rdReq,
  input logic [PAGE_W-1:0] rdPage,
  input logic              rdAck,
  input logic              found,
  input logic              fail
);
  // R8: the two verdicts exclude each other
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(found && fail));

  // R8: verdicts held until a new start
  a_r8_found_held: assert property (@(posedge clk) disable iff (!rstN)
    (found && !start) |=> found);
  a_r8_fail_held: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !start) |=> fail);

  // R6, R7: no reads once a verdict is out
  a_r6_quiet_when_done: assert property (@(posedge clk) disable iff (!rstN)
    (found || fail) |-> !rdReq);

  // R2: request held steady until acknowledged
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdPage)));

  // R2, R7: requested pages lie on the probe grid within the budget
  a_r2_page_grid: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> ((int'(rdPage) % PROBE_STRIDE) == 0 &&
               int'(rdPage) < MAX_PROBES * PROBE_STRIDE));
endmodule

bind nand_boot_scan nbs_checker #(
  .PAGE_W(PAGE_W), .PROBE_STRIDE(PROBE_STRIDE), .MAX_PROBES(MAX_PROBES)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .rdReq(rdReq), .rdPage(rdPage),
  .rdAck(rdAck), .found(found), .fail(fail)
);

// File: tb/nand_boot_scan_tb.sv
module nand_boot_scan_tb;
  localparam int PAGE_W = 16;
  localparam int WATCHDOG = 190000;

  typedef struct packed {
    logic [7:0]  matchProbe;   // 50 means no match
    logic [1:0]  badKind;      // 1 sig, 2 marker, 3 alternate
    logic [15:0] off;
    logic [15:0] size;
    logic [3:0]  gap;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0,  2'd1, 16'h0004, 16'h1234, 4'd0},
    '{8'd3,  2'd1, 16'hBEEF, 16'hFFFF, 4'd2},
    '{8'd5,  2'd2, 16'h0100, 16'h0001, 4'd1},
    '{8'd49, 2'd3, 16'h7F80, 16'h8000, 4'd0},
    '{8'd50, 2'd3, 16'h0000, 16'h0000, 4'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rdReq, rdAck = 1'b0;
  logic [PAGE_W-1:0] rdPage, hitPage;
  logic byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic found, fail;
  logic [15:0] stageOffset, codeSize;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int curMatch = 0;
  int curKind = 1;
  int curGap = 0;
  logic [15:0] curOff = '0, curSize = '0;
  int reqCount = 0;
  int pageErr = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  nand_boot_scan #(.PAGE_W(PAGE_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .rdReq(rdReq), .rdPage(rdPage),
    .rdAck(rdAck), .byteValid(byteValid), .byteData(byteData),
    .found(found), .fail(fail), .stageOffset(stageOffset),
    .codeSize(codeSize), .hitPage(hitPage)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sigByte(int i);
    case (i)
      0: return 8'h55;
      1: return 8'hAA;
      2: return 8'hF0;
      default: return 8'h0F;
    endcase
  endfunction

  // Sector content for probe k; good when k equals the match probe
  function automatic logic [7:0] sectorByte(int probe, int i);
    logic good;
    logic [15:0] o, s;
    int kind;
    good = (probe == curMatch);
    o = good ? curOff : 16'hDEAD;
    s = good ? curSize : 16'h0BAD;
    kind = curKind;
    if (kind == 3) kind = (probe % 2 == 1) ? 1 : 2;
    if (!good && kind == 1 && i == probe % 4) return sigByte(i) ^ 8'h01; // R3
    if (!good && kind == 2 && i == 514) return 8'h68;                    // R4
    if (i < 4) return sigByte(i);
    if (i == 12) return o[7:0];
    if (i == 13) return o[15:8];
    if (i == 508) return s[7:0];
    if (i == 509) return s[15:8];
    if (i == 514) return 8'h69;
    return 8'((i * 13 + probe) & 255);
  endfunction

  // Fetch unit model
  initial begin
    forever begin
      @(negedge clk);
      if (rdReq) begin
        if (int'(rdPage) != reqCount * 64) pageErr++;
        // stray byte before acknowledge: must be ignored (R9)
        byteValid = 1'b1;
        byteData = 8'h55;
        @(negedge clk);
        byteValid = 1'b0;
        rdAck = 1'b1;
        @(negedge clk);
        rdAck = 1'b0;
        for (int i = 0; i < 528; i++) begin
          for (int g = 0; g < curGap; g++) @(negedge clk);
          byteValid = 1'b1;
          byteData = sectorByte(reqCount, i);
          @(negedge clk);
          byteValid = 1'b0;
        end
        reqCount++;
      end
    end
  end

  initial begin
    @(posedge clk);
    while (cycles < WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!(found || fail) && cycles < WATCHDOG) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 found", 32'(found), 32'd0);
    chk("R1 fail", 32'(fail), 32'd0);
    chk("R1 rdReq", 32'(rdReq), 32'd0);
    chk("R1 fields", {stageOffset, codeSize}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 hitPage after release", 32'(hitPage), 32'd0);

    for (int v = 0; v < NVEC; v++) begin
      curMatch = int'(VECS[v].matchProbe);
      curKind = int'(VECS[v].badKind);
      curGap = int'(VECS[v].gap);
      curOff = VECS[v].off;
      curSize = VECS[v].size;
      reqCount = 0;
      pageErr = 0;
      pulseStart();
      // R8: start clears earlier verdict
      chk("R8 cleared on start", {30'd0, found, fail}, 32'd0);
      waitDone();
      @(negedge clk);
      chk("R2 page sequence", 32'(pageErr), 32'd0);
      if (curMatch < 50) begin
        // R3 R4 R9: earlier invalid probes rejected, match accepted
        chk("R6 found", {30'd0, found, fail}, 32'd2);
        chk("R5 stageOffset", 32'(stageOffset), 32'(curOff));
        chk("R5 codeSize", 32'(codeSize), 32'(curSize));
        chk("R6 hitPage", 32'(hitPage), 32'(curMatch * 64));
        chk("R7 request count", 32'(reqCount), 32'(curMatch + 1));
      end else begin
        chk("R7 fail", {30'd0, found, fail}, 32'd1);
        chk("R7 request count", 32'(reqCount), 32'd50);
      end
      repeat (20) @(negedge clk);
      chk("R6 no request after verdict", 32'(rdReq), 32'd0);
      chk("R8 verdict held", {30'd0, found, fail}, curMatch < 50 ? 32'd2 : 32'd1);
    end

    // R8: start during a scan is ignored
    curMatch = 2;
    curKind = 2;
    curGap = 0;
    curOff = 16'h0A0B;
    curSize = 16'h0C0D;
    reqCount = 0;
    pageErr = 0;
    pulseStart();
    repeat (100) @(negedge clk);
    pulseStart();
    waitDone();
    @(negedge clk);
    chk("R8 busy start ignored pages", 32'(pageErr), 32'd0);
    chk("R8 busy start ignored count", 32'(reqCount), 32'd3);
    chk("R8 busy start result", {15'd0, found, hitPage}, {15'd0, 1'b1, 16'd128});
    chk("R5 fields after busy start", {stageOffset, codeSize}, 32'h0A0B0C0D);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule